// File: doc/BRIEF.md
# Packed SIMD Shift Execution Unit

This unit performs one shift operation on a 32-bit source word treated as four independent bytes, as two independent halfwords, or as a single word. A 5-bit sub-operation code chooses both the lane layout and the kind of shift. The kinds are logical left, logical right, arithmetic right, arithmetic right with round-to-nearest, and saturating left. The shift count comes either from a 5-bit immediate or from the low bits of a register operand.

An issue strobe presents one operation. The unit computes it combinationally and registers the result, an overflow pulse and an illegal-operation marker, which all appear on the following cycle. The overflow pulse is meant to set a sticky bit in a control register that lives outside the block. Sub-operation codes that map to no operation give a zero result, raise the illegal marker and never signal overflow.

Top module: `shv_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `res_data`, `res_ovf` and `res_illegal` are all zero.
- R2: An operation issued with `op_valid` high appears on the outputs after the next rising clock edge, together with `res_valid` high. In any cycle after an edge where `op_valid` was low, `res_valid`, `res_ovf` and `res_illegal` are low, so each flag lasts exactly one cycle per operation.
- R3: Byte lanes occupy bits [31:24], [23:16], [15:8] and [7:0], and halfword lanes occupy [31:16] and [15:0]. Every lane uses the same count, is processed independently, and is written back to its own position.
- R4: Codes with bit 1 set take the count from `amt_reg`: bits [2:0] for byte lanes, [3:0] for halfwords and [4:0] for the word. Codes with bit 1 clear take the count from `imm_amt`, reduced to the same low bits.
- R5: Byte codes: 0x00/0x02 left, 0x01/0x03 logical right, 0x04/0x06 arithmetic right, 0x05/0x07 rounding right. Halfword codes: 0x08/0x0A left, 0x09/0x0B arithmetic right, 0x0C/0x0E saturating left, 0x0D/0x0F rounding right, 0x19/0x1B logical right. Word codes: 0x14/0x16 saturating left, 0x15/0x17 rounding right.
- R6: A plain left shift keeps the low lane bits and wraps. A logical right shift fills with zeros.
- R7: An arithmetic right shift treats each lane as signed and fills with copies of its sign bit.
- R8: A rounding right shift by n>0 sign-extends the lane by one bit and shifts it right arithmetically by n-1. It then adds 1, shifts right by one more and keeps the low lane-width bits.
- R9: A plain or rounding arithmetic right shift by a count of zero returns the lane unchanged.
- R10: A saturating left shift whose signed result does not fit the lane returns 0x7FFF/0x7FFFFFFF for a non-negative input and 0x8000/0x80000000 for a negative input.
- R11: `res_ovf` is high when any lane of a plain or saturating left shift loses a bit that differs from the result's sign bit. Right shifts never raise it.
- R12: Codes 0x10–0x13, 0x18, 0x1A and 0x1C–0x1F give `res_data` = 0 and `res_ovf` = 0, with `res_illegal` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe for one operation |
| sub_op | input | 5 | Sub-operation code |
| imm_amt | input | 5 | Immediate shift count |
| amt_reg | input | 32 | Register operand holding a variable shift count |
| src | input | 32 | Data operand to be shifted |
| res_valid | output | 1 | Result registered this cycle |
| res_data | output | 32 | Shifted result |
| res_ovf | output | 1 | One-cycle overflow pulse |
| res_illegal | output | 1 | One-cycle unknown-code marker |

## Verification
The bench targets the cases where each lane width behaves differently.

- Rounding right shifts are driven at the extremes, with the most negative lane value and with counts of 1 and lane-width minus one. A design that forgets the one-bit sign extension, or rounds in the wrong direction, returns values off by one in these cases.
- Saturating shifts are driven just inside and just outside the range, including a word shifted by 31 whose result is exactly 0x80000000 and must not raise overflow. A comparison that is off by one bit either clamps this legal value or lets a real overflow wrap.
- Register counts carry junk in their upper bits, which exposes a design that masks the count to the wrong width.
- Neighbouring byte lanes are given values of opposite sign, which exposes carries or sign fill that leak across lane boundaries.

// File: rtl/shv_pkg.sv
package shv_pkg;

   typedef enum logic [2:0] {
      SK_NONE,
      SK_SLL,
      SK_SRL,
      SK_SRA,
      SK_RND,
      SK_SAT
   } shv_kind_e;

   typedef enum logic [1:0] {
      SW_BYTE,
      SW_HALF,
      SW_WORD
   } shv_width_e;

   typedef struct packed {
      shv_kind_e  kind;
      shv_width_e width;
      logic       use_reg;
      logic       bad;
   } shv_ctl_t;

endpackage

// File: rtl/shv_decode.sv
module shv_decode
   import shv_pkg::*;
(
   input  logic [4:0] sub_op,
   output shv_ctl_t   ctl
);

   always_comb begin
      ctl.kind    = SK_NONE;
      ctl.width   = SW_BYTE;
      ctl.use_reg = sub_op[1];
      ctl.bad     = 1'b0;
      unique case (sub_op)
         5'h00, 5'h02: begin ctl.kind = SK_SLL; ctl.width = SW_BYTE; end
         5'h01, 5'h03: begin ctl.kind = SK_SRL; ctl.width = SW_BYTE; end
         5'h04, 5'h06: begin ctl.kind = SK_SRA; ctl.width = SW_BYTE; end
         5'h05, 5'h07: begin ctl.kind = SK_RND; ctl.width = SW_BYTE; end
         5'h08, 5'h0A: begin ctl.kind = SK_SLL; ctl.width = SW_HALF; end
         5'h09, 5'h0B: begin ctl.kind = SK_SRA; ctl.width = SW_HALF; end
         5'h0C, 5'h0E: begin ctl.kind = SK_SAT; ctl.width = SW_HALF; end
         5'h0D, 5'h0F: begin ctl.kind = SK_RND; ctl.width = SW_HALF; end
         5'h19, 5'h1B: begin ctl.kind = SK_SRL; ctl.width = SW_HALF; end
         5'h14, 5'h16: begin ctl.kind = SK_SAT; ctl.width = SW_WORD; end
         5'h15, 5'h17: begin ctl.kind = SK_RND; ctl.width = SW_WORD; end
         default: begin
            ctl.bad     = 1'b1;
            ctl.use_reg = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/shv_lane.sv
module shv_lane
   import shv_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]         x,
   input  logic [$clog2(W)-1:0] amt,
   input  shv_kind_e            kind,
   output logic [W-1:0]         y,
   output logic                 ovf
);

   localparam int AW = $clog2(W);

   logic [2*W-1:0]  wide;
   logic [W:0]      top_bits;
   logic            fits;
   logic signed [W:0] ext;
   logic signed [W:0] pre;
   logic [W:0]      sum;
   logic [AW-1:0]   amt_m1;
   logic [W-1:0]    sat_val;

   // sign-extended left shift: the upper W+1 bits must agree for the result to fit
   assign wide     = {{W{x[W-1]}}, x} << amt;
   assign top_bits = wide[2*W-1:W-1];
   assign fits     = (&top_bits) | ~(|top_bits);
   assign sat_val  = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

   // rounding path in W+1 bits so the +1 cannot overflow
   assign ext    = $signed({x[W-1], x});
   assign amt_m1 = amt - AW'(1);
   assign pre    = ext >>> amt_m1;
   assign sum    = pre + (W+1)'(1);

   always_comb begin
      y   = '0;
      ovf = 1'b0;
      unique case (kind)
         SK_SLL: begin
            y   = wide[W-1:0];
            ovf = ~fits;
         end
         SK_SRL: y = x >> amt;
         SK_SRA: y = $signed(x) >>> amt;
         SK_RND: y = (amt == '0) ? x : sum[W:1];
         SK_SAT: begin
            y   = fits ? wide[W-1:0] : sat_val;
            ovf = ~fits;
         end
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/shv_unit.sv
module shv_unit
   import shv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       op_valid,
   input  logic [4:0]                 sub_op,
   input  logic [$clog2(DATA_W)-1:0]  imm_amt,
   input  logic [DATA_W-1:0]          amt_reg,
   input  logic [DATA_W-1:0]          src,
   output logic                       res_valid,
   output logic [DATA_W-1:0]          res_data,
   output logic                       res_ovf,
   output logic                       res_illegal
);

   localparam int SH_W   = $clog2(DATA_W);
   localparam int B_W    = DATA_W / 4;
   localparam int H_W    = DATA_W / 2;
   localparam int B_AW   = $clog2(B_W);
   localparam int H_AW   = $clog2(H_W);
   localparam int N_BYTE = DATA_W / B_W;
   localparam int N_HALF = DATA_W / H_W;

   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("shv_unit: DATA_W must be a power of two of at least 16");
      end
   endgenerate

   shv_ctl_t            ctl;
   logic [SH_W-1:0]     amt_sel;
   logic [DATA_W-1:0]   byte_y, half_y, word_y;
   logic [N_BYTE-1:0]   byte_ovf;
   logic [N_HALF-1:0]   half_ovf;
   logic                word_ovf;
   logic [DATA_W-1:0]   nxt_data;
   logic                nxt_ovf;

   shv_decode u_dec (
      .sub_op (sub_op),
      .ctl    (ctl)
   );

   assign amt_sel = ctl.use_reg ? amt_reg[SH_W-1:0] : imm_amt;

   generate
      for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
         shv_lane #(.W(B_W)) u_lane (
            .x    (src[i*B_W +: B_W]),
            .amt  (amt_sel[B_AW-1:0]),
            .kind (ctl.kind),
            .y    (byte_y[i*B_W +: B_W]),
            .ovf  (byte_ovf[i])
         );
      end
      for (genvar j = 0; j < N_HALF; j++) begin : g_half
         shv_lane #(.W(H_W)) u_lane (
            .x    (src[j*H_W +: H_W]),
            .amt  (amt_sel[H_AW-1:0]),
            .kind (ctl.kind),
            .y    (half_y[j*H_W +: H_W]),
            .ovf  (half_ovf[j])
         );
      end
   endgenerate

   shv_lane #(.W(DATA_W)) u_word (
      .x    (src),
      .amt  (amt_sel),
      .kind (ctl.kind),
      .y    (word_y),
      .ovf  (word_ovf)
   );

   always_comb begin
      nxt_data = '0;
      nxt_ovf  = 1'b0;
      if (!ctl.bad) begin
         unique case (ctl.width)
            SW_BYTE: begin nxt_data = byte_y; nxt_ovf = |byte_ovf; end
            SW_HALF: begin nxt_data = half_y; nxt_ovf = |half_ovf; end
            SW_WORD: begin nxt_data = word_y; nxt_ovf = word_ovf;  end
            default: begin nxt_data = '0;     nxt_ovf = 1'b0;      end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_data    <= '0;
         res_ovf     <= 1'b0;
         res_illegal <= 1'b0;
      end else begin
         res_valid   <= op_valid;
         res_ovf     <= op_valid & nxt_ovf;
         res_illegal <= op_valid & ctl.bad;
         if (op_valid) begin
            res_data <= nxt_data;
         end
      end
   end

endmodule

// File: rtl/shv_unit_chk.sv
module shv_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      op_valid,
   input logic [4:0]                sub_op,
   input logic [$clog2(DATA_W)-1:0] imm_amt,
   input logic [DATA_W-1:0]         amt_reg,
   input logic [DATA_W-1:0]         src,
   input logic                      res_valid,
   input logic [DATA_W-1:0]         res_data,
   input logic                      res_ovf,
   input logic                      res_illegal
);

   localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && !res_ovf && !res_illegal));

   assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_ovf || res_illegal) |-> res_valid);

   assert_illegal_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> (res_data == '0 && !res_ovf));

   assert_zero_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && sub_op == 5'h17 && amt_reg[$clog2(DATA_W)-1:0] == '0)
      |=> res_data == $past(src));

   assert_sat_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (sub_op == 5'h14 || sub_op == 5'h16))
      |=> (!res_ovf || res_data == MAX_POS || res_data == MAX_NEG));

   assert_right_no_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (sub_op == 5'h01 || sub_op == 5'h15 || sub_op == 5'h19))
      |=> !res_ovf);

endmodule

bind shv_unit shv_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .sub_op      (sub_op),
   .imm_amt     (imm_amt),
   .amt_reg     (amt_reg),
   .src         (src),
   .res_valid   (res_valid),
   .res_data    (res_data),
   .res_ovf     (res_ovf),
   .res_illegal (res_illegal)
);

// File: tb/tb_shv_unit.sv
`timescale 1ns/1ps
module tb_shv_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [4:0]  sub_op;
   logic [4:0]  imm_amt;
   logic [31:0] amt_reg;
   logic [31:0] src;
   logic        res_valid;
   logic [31:0] res_data;
   logic        res_ovf;
   logic        res_illegal;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   shv_unit #(.DATA_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .sub_op(sub_op),
      .imm_amt(imm_amt), .amt_reg(amt_reg), .src(src), .res_valid(res_valid),
      .res_data(res_data), .res_ovf(res_ovf), .res_illegal(res_illegal)
   );

   typedef struct packed {
      logic [4:0]  sub;
      logic [4:0]  imm;
      logic [31:0] amt;
      logic [31:0] src;
      logic [31:0] exp;
      logic        ovf;
      logic        ill;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      '{5'h00, 5'd2,  32'h0,        32'h0110F0FF, 32'h0440C0FC, 1'b0, 1'b0, 4'd6},  // R6 byte left, no loss
      '{5'h00, 5'd2,  32'h0,        32'h0120C0FF, 32'h048000FC, 1'b1, 1'b0, 4'd11}, // R11 sign change in two lanes
      '{5'h01, 5'd3,  32'h0,        32'h80FF1007, 32'h101F0200, 1'b0, 1'b0, 4'd6},  // R6 zero fill
      '{5'h03, 5'd5,  32'hFFFFFFF9, 32'h80FF1007, 32'h407F0803, 1'b0, 1'b0, 4'd4},  // R4 low 3 bits of register
      '{5'h04, 5'd2,  32'h0,        32'h807FFC03, 32'hE01FFF00, 1'b0, 1'b0, 4'd7},  // R7 signed bytes
      '{5'h05, 5'd1,  32'h0,        32'h03FD0580, 32'h02FF03C0, 1'b0, 1'b0, 4'd8},  // R8 byte rounding
      '{5'h07, 5'd3,  32'h00000008, 32'h12345678, 32'h12345678, 1'b0, 1'b0, 4'd9},  // R9 count masks to 0
      '{5'h06, 5'd0,  32'h00000007, 32'h807FFF01, 32'hFF00FF00, 1'b0, 1'b0, 4'd3},  // R3 lanes independent
      '{5'h02, 5'd0,  32'h0000000B, 32'h01020304, 32'h08101820, 1'b0, 1'b0, 4'd4},  // R4 byte variable left
      '{5'h08, 5'd4,  32'h0,        32'h0123F800, 32'h12308000, 1'b0, 1'b0, 4'd3},  // R3 halfword lanes
      '{5'h0C, 5'd2,  32'h0,        32'h40009000, 32'h7FFF8000, 1'b1, 1'b0, 4'd10}, // R10 both clamps
      '{5'h0E, 5'd0,  32'h00000011, 32'h3FFFC000, 32'h7FFE8000, 1'b0, 1'b0, 4'd10}, // R10 just fits
      '{5'h09, 5'd4,  32'h0,        32'h80007FF0, 32'hF80007FF, 1'b0, 1'b0, 4'd7},  // R7 halfword
      '{5'h0D, 5'd2,  32'h0,        32'h0006FFFA, 32'h0002FFFF, 1'b0, 1'b0, 4'd8},  // R8 halfword
      '{5'h0F, 5'd0,  32'h0000002F, 32'h7FFF8000, 32'h0001FFFF, 1'b0, 1'b0, 4'd8},  // R8 count 15
      '{5'h19, 5'd8,  32'h0,        32'hABCD8001, 32'h00AB0080, 1'b0, 1'b0, 4'd5},  // R5 halfword logical right
      '{5'h1B, 5'd7,  32'h00000010, 32'hABCD8001, 32'hABCD8001, 1'b0, 1'b0, 4'd4},  // R4 low 4 bits zero
      '{5'h0A, 5'd0,  32'h00000021, 32'h40000001, 32'h80000002, 1'b1, 1'b0, 4'd6},  // R6 wraps, flags
      '{5'h0B, 5'd0,  32'h0000000F, 32'h80007FFF, 32'hFFFF0000, 1'b0, 1'b0, 4'd7},  // R7 count 15
      '{5'h14, 5'd1,  32'h0,        32'h40000000, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd10}, // R10 word positive
      '{5'h14, 5'd4,  32'h0,        32'h90000000, 32'h80000000, 1'b1, 1'b0, 4'd10}, // R10 word negative
      '{5'h16, 5'd0,  32'h000000E4, 32'hF8000000, 32'h80000000, 1'b0, 1'b0, 4'd11}, // R11 exact minimum
      '{5'h16, 5'd0,  32'h0000001F, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b0, 4'd11}, // R11 shift by 31
      '{5'h15, 5'd31, 32'h0,        32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 4'd8},  // R8 word count 31
      '{5'h17, 5'd9,  32'h00000020, 32'h87654321, 32'h87654321, 1'b0, 1'b0, 4'd9},  // R9 word zero count
      '{5'h10, 5'd5,  32'h0,        32'h40404040, 32'h00000000, 1'b0, 1'b1, 4'd12}, // R12
      '{5'h1A, 5'd5,  32'h5,        32'h40404040, 32'h00000000, 1'b0, 1'b1, 4'd12}, // R12
      '{5'h1F, 5'd5,  32'h0,        32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 4'd5}   // R5 unmapped code
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [4:0] s, input logic [4:0] i, input logic [31:0] a,
                        input logic [31:0] d);
      op_valid = 1'b1;
      sub_op   = s;
      imm_amt  = i;
      amt_reg  = a;
      src      = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; op_valid = 1'b0; sub_op = '0; imm_amt = '0; amt_reg = '0; src = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 valid", {31'b0, res_valid}, 32'h0);
      chk("R1 data", res_data, 32'h0);
      chk("R1 flags", {30'b0, res_ovf, res_illegal}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         issue(VECS[k].sub, VECS[k].imm, VECS[k].amt, VECS[k].src);
         total++;
         if (res_valid !== 1'b1 || res_data !== VECS[k].exp ||
             res_ovf !== VECS[k].ovf || res_illegal !== VECS[k].ill) begin
            bad++;
            $display("FAIL R%0d vec %0d act=%h/%b/%b/%b exp=%h/1/%b/%b", VECS[k].req, k,
                     res_data, res_valid, res_ovf, res_illegal,
                     VECS[k].exp, VECS[k].ovf, VECS[k].ill);
         end
      end

      // R2: the overflow pulse lasts one cycle, and nothing is flagged while idle
      issue(5'h14, 5'd1, 32'h0, 32'h40000000);
      chk("R2 ovf pulse", {31'b0, res_ovf}, 32'h1);
      op_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R2 idle valid", {31'b0, res_valid}, 32'h0);
      chk("R2 idle ovf", {31'b0, res_ovf}, 32'h0);

      // R2: an illegal marker also drops once idle
      issue(5'h13, 5'd0, 32'h0, 32'h1);
      chk("R12 illegal", {31'b0, res_illegal}, 32'h1);
      op_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R2 illegal clears", {31'b0, res_illegal}, 32'h0);

      // R4: the immediate is ignored by a variable code, and the register by an immediate code
      issue(5'h01, 5'd4, 32'h00000001, 32'hF0F0F0F0);
      chk("R4 imm form", res_data, 32'h0F0F0F0F);
      issue(5'h03, 5'd4, 32'h00000001, 32'hF0F0F0F0);
      chk("R4 reg form", res_data, 32'h78787878);

      // R9: arithmetic right shift by zero leaves lanes unchanged
      issue(5'h09, 5'd0, 32'h0, 32'h8001FFFE);
      chk("R9 sra zero", res_data, 32'h8001FFFE);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule